// File: doc/BRIEF.md
# Deep Event Buffer Occupancy Monitor and Throttle

This block follows how many events sit in the deep second-stage front-end buffer. Each first-stage accept adds one event. Each second-stage decision that leaves the block removes one event, whether that decision is an accept or a reject. Incoming second-stage decisions go into a small queue. They leave it at no more than one every SPACING clocks, which is 36 clocks (900 ns at 40 MHz) by default, so that each event's 36-word readout can finish before the next decision is issued.

Two back-pressure paths act on the trigger flow. A nearly-full warning from the data-acquisition side raises a flag, and while that flag is set every issued accept leaves as a reject. A nearly-full warning from a board or system, or an occupancy at or above a programmable threshold, raises the throttle that blocks new first-stage triggers. Sticky error flags record three faults: queue overflow, counter overflow and counter underflow. Only the reset input clears them.

Top module: `deep_buf_throttle`

## Requirements
- R1: After a synchronous reset the block shows the following at its ports: occupancy 0, threshold readback 990, and every strobe, flag, throttle and error output at 0.
- R2: Occupancy rises by one on each clock with `l1_acc_i` high and falls by one on each clock with an issued decision. When both happen in the same clock it stays unchanged. The new value appears one clock after the sampling edge.
- R3: A queued decision is issued with `dec_strobe_o` high for one clock. Two issues are at least SPACING clocks apart. When the gap has already elapsed, the strobe appears in the clock after the edge that first sees the decision in the queue.
- R4: Decisions are issued in arrival order. The queue holds up to FIFO_DEPTH (8) entries, and an issue and an arrival in the same clock are both accepted.
- R5: `acc_to_rej_o` is `daq_nfull_i` delayed by one clock. An issue made while `acc_to_rej_o` is 1 always gives `dec_accept_o`=0. Otherwise `dec_accept_o` equals the queued decision, where 1 means accept.
- R6: `l1_throttle_o` is registered. It goes high one clock after `board_nfull_i` is high, or one clock after occupancy is at or above the threshold.
- R7: A clock with `thr_we_i` high loads `thr_wdata_i` into the threshold, and `thr_rdata_o` shows the new value one clock later.
- R8: An accept that arrives at occupancy MAX_EVENTS (1000), or an issue at occupancy 0, leaves the occupancy unchanged and sets the sticky `err_count_o`.
- R9: A decision that arrives while the queue is full and no issue happens in that clock is dropped, and it sets the sticky `err_fifo_o`. Both error flags stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l1_acc_i | input | 1 | First-stage accept, one event per high clock |
| dec_valid_i | input | 1 | Second-stage decision arrives |
| dec_accept_i | input | 1 | Decision kind: 1 accept, 0 reject |
| daq_nfull_i | input | 1 | Downstream nearly full |
| board_nfull_i | input | 1 | Board or system nearly full |
| thr_we_i | input | 1 | Threshold write enable |
| thr_wdata_i | input | CNT_W | Threshold write value |
| thr_rdata_o | output | CNT_W | Threshold readback |
| occupancy_o | output | CNT_W | Events held in the buffer |
| dec_strobe_o | output | 1 | Paced decision issue |
| dec_accept_o | output | 1 | Issued decision kind, 1 accept |
| acc_to_rej_o | output | 1 | Accepts are being turned into rejects |
| l1_throttle_o | output | 1 | Block new first-stage triggers |
| err_fifo_o | output | 1 | Sticky decision queue overflow |
| err_count_o | output | 1 | Sticky occupancy overflow or underflow |

## Verification
A wrong queue pointer or count shows at the ports within SPACING clocks. It appears either as a decision of the wrong kind, or as a strobe that comes early, late or not at all compared with a model of arrival order and spacing. An occupancy slip shows on `occupancy_o` one clock after the faulty update and never heals, because the counter only steps by one. The bench compares every output against the model on every clock, so any state fault is reported in the clock where it first becomes visible. A slipped occupancy also shifts the throttle edge and the point where the error flags set.

// File: rtl/deep_buf_pkg.sv
package deep_buf_pkg;
  typedef enum logic {DEC_REJECT = 1'b0, DEC_ACCEPT = 1'b1} dec_kind_e;
endpackage

// File: rtl/dec_fifo.sv
module dec_fifo
  import deep_buf_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_i,
  input  dec_kind_e wdata_i,
  input  logic      rd_i,
  output dec_kind_e rdata_o,
  output logic      empty_o,
  output logic      ovf_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  dec_kind_e        mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] fill;
  logic             full, wr_ok, rd_ok;

  assign full    = (fill == CNT_W'(DEPTH));
  assign empty_o = (fill == '0);
  assign rd_ok   = rd_i && !empty_o;
  assign wr_ok   = wr_i && (!full || rd_ok);
  assign rdata_o = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      fill  <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (wr_ok) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      if (wr_ok && !rd_ok)      fill <= fill + 1'b1;
      else if (rd_ok && !wr_ok) fill <= fill - 1'b1;
      if (wr_i && !wr_ok) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dec_pacer.sv
module dec_pacer
  import deep_buf_pkg::*;
#(
  parameter int SPACING = 36
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      avail_i,
  input  dec_kind_e head_i,
  input  logic      convert_i,
  output logic      pop_o,
  output logic      strobe_o,
  output logic      accept_o
);
  localparam int GAP_W = (SPACING > 2) ? $clog2(SPACING) : 1;

  logic [GAP_W-1:0] gap;

  assign pop_o = avail_i && (gap == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      gap      <= '0;
      strobe_o <= 1'b0;
      accept_o <= 1'b0;
    end else begin
      strobe_o <= pop_o;
      accept_o <= pop_o && (head_i == DEC_ACCEPT) && !convert_i;
      if (pop_o)            gap <= GAP_W'(SPACING - 1);
      else if (gap != '0)   gap <= gap - 1'b1;
    end
  end
endmodule

// File: rtl/occ_counter.sv
module occ_counter #(
  parameter int MAX_EVENTS = 1000,
  parameter int CNT_W      = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o,
  output logic             err_o
);
  logic at_max, at_zero;

  assign at_max  = (count_o == CNT_W'(MAX_EVENTS));
  assign at_zero = (count_o == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
      err_o   <= 1'b0;
    end else if (inc_i && !dec_i) begin
      if (at_max) err_o   <= 1'b1;
      else        count_o <= count_o + 1'b1;
    end else if (dec_i && !inc_i) begin
      if (at_zero) err_o   <= 1'b1;
      else         count_o <= count_o - 1'b1;
    end
  end
endmodule

// File: rtl/deep_buf_throttle.sv
module deep_buf_throttle
  import deep_buf_pkg::*;
#(
  parameter int MAX_EVENTS = 1000,
  parameter int SPACING    = 36,
  parameter int FIFO_DEPTH = 8,
  parameter int THR_RESET  = 990,
  localparam int CNT_W     = $clog2(MAX_EVENTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             l1_acc_i,
  input  logic             dec_valid_i,
  input  logic             dec_accept_i,
  input  logic             daq_nfull_i,
  input  logic             board_nfull_i,
  input  logic             thr_we_i,
  input  logic [CNT_W-1:0] thr_wdata_i,
  output logic [CNT_W-1:0] thr_rdata_o,
  output logic [CNT_W-1:0] occupancy_o,
  output logic             dec_strobe_o,
  output logic             dec_accept_o,
  output logic             acc_to_rej_o,
  output logic             l1_throttle_o,
  output logic             err_fifo_o,
  output logic             err_count_o
);
  dec_kind_e head, in_kind;
  logic      empty, pop;

  assign in_kind = dec_accept_i ? DEC_ACCEPT : DEC_REJECT;

  dec_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_i(dec_valid_i), .wdata_i(in_kind),
    .rd_i(pop), .rdata_o(head), .empty_o(empty), .ovf_o(err_fifo_o)
  );

  dec_pacer #(.SPACING(SPACING)) u_pacer (
    .clk(clk), .rst(rst), .avail_i(!empty), .head_i(head),
    .convert_i(acc_to_rej_o), .pop_o(pop),
    .strobe_o(dec_strobe_o), .accept_o(dec_accept_o)
  );

  occ_counter #(.MAX_EVENTS(MAX_EVENTS), .CNT_W(CNT_W)) u_occ (
    .clk(clk), .rst(rst), .inc_i(l1_acc_i), .dec_i(pop),
    .count_o(occupancy_o), .err_o(err_count_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_rdata_o   <= CNT_W'(THR_RESET);
      acc_to_rej_o  <= 1'b0;
      l1_throttle_o <= 1'b0;
    end else begin
      if (thr_we_i) thr_rdata_o <= thr_wdata_i;
      acc_to_rej_o  <= daq_nfull_i;
      l1_throttle_o <= board_nfull_i || (occupancy_o >= thr_rdata_o);
    end
  end
endmodule

// File: rtl/deep_buf_throttle_chk.sv
module deep_buf_throttle_chk #(
  parameter int MAX_EVENTS = 1000,
  parameter int SPACING    = 36,
  parameter int CNT_W      = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             board_nfull_i,
  input logic [CNT_W-1:0] occupancy_o,
  input logic             dec_strobe_o,
  input logic             dec_accept_o,
  input logic             acc_to_rej_o,
  input logic             l1_throttle_o,
  input logic             err_fifo_o,
  input logic             err_count_o
);
  localparam int SW = $clog2(SPACING + 1);
  logic [SW-1:0] since;

  always_ff @(posedge clk) begin
    if (rst)                         since <= SW'(SPACING);
    else if (dec_strobe_o)           since <= SW'(1);
    else if (since < SW'(SPACING))   since <= since + 1'b1;
  end

  // R3
  spacing_chk: assert property (@(posedge clk) disable iff (rst)
    dec_strobe_o |-> (since >= SW'(SPACING)));
  // R3
  accept_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    dec_accept_o |-> dec_strobe_o);
  // R5
  convert_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_strobe_o && $past(acc_to_rej_o)) |-> !dec_accept_o);
  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    occupancy_o <= CNT_W'(MAX_EVENTS));
  // R6
  board_throttle_chk: assert property (@(posedge clk) disable iff (rst)
    board_nfull_i |=> l1_throttle_o);
  // R8
  count_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_count_o |=> err_count_o);
  // R9
  fifo_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_fifo_o |=> err_fifo_o);
endmodule

bind deep_buf_throttle deep_buf_throttle_chk #(
  .MAX_EVENTS(MAX_EVENTS), .SPACING(SPACING), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .board_nfull_i(board_nfull_i),
  .occupancy_o(occupancy_o), .dec_strobe_o(dec_strobe_o),
  .dec_accept_o(dec_accept_o), .acc_to_rej_o(acc_to_rej_o),
  .l1_throttle_o(l1_throttle_o), .err_fifo_o(err_fifo_o),
  .err_count_o(err_count_o)
);

// File: tb/deep_buf_throttle_tb.sv
module deep_buf_throttle_tb;
  localparam int MAXE = 1000, SP = 36, DEP = 8, W = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic l1 = 0, dv = 0, da = 0, daq = 0, brd = 0, we = 0;
  logic [W-1:0] wd = '0;
  logic [W-1:0] thr_o, occ_o;
  logic stb, acc, a2r, thro, efifo, ecnt;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit cmp_on = 0;

  deep_buf_throttle u_dut (
    .clk(clk), .rst(rst), .l1_acc_i(l1), .dec_valid_i(dv), .dec_accept_i(da),
    .daq_nfull_i(daq), .board_nfull_i(brd), .thr_we_i(we), .thr_wdata_i(wd),
    .thr_rdata_o(thr_o), .occupancy_o(occ_o), .dec_strobe_o(stb),
    .dec_accept_o(acc), .acc_to_rej_o(a2r), .l1_throttle_o(thro),
    .err_fifo_o(efifo), .err_count_o(ecnt)
  );

  always #10 clk = ~clk;

  // reference model, built from the requirements
  bit m_q [DEP];
  int m_qn, m_gap, m_occ, m_thr;
  bit m_stb, m_acc, m_a2r, m_thro, m_ef, m_ec;

  function automatic bit pop_now(int qn, int gap);
    return (qn > 0) && (gap == 0);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_qn = 0; m_gap = 0; m_occ = 0; m_thr = 990;
      m_stb = 0; m_acc = 0; m_a2r = 0; m_thro = 0; m_ef = 0; m_ec = 0;
      cmp_on = 1;
    end else begin
      bit p, hd;
      p = pop_now(m_qn, m_gap);
      hd = m_q[0];
      m_thro = brd || (m_occ >= m_thr);
      m_stb = p;
      m_acc = p && hd && !m_a2r;
      m_a2r = daq;
      if (p) begin
        for (int i = 0; i < DEP - 1; i++) m_q[i] = m_q[i+1];
        m_qn--;
      end
      if (dv) begin
        if (m_qn < DEP) begin m_q[m_qn] = da; m_qn++; end
        else m_ef = 1;
      end
      if (p) m_gap = SP - 1; else if (m_gap > 0) m_gap--;
      if (l1 && !p) begin
        if (m_occ == MAXE) m_ec = 1; else m_occ++;
      end else if (p && !l1) begin
        if (m_occ == 0) m_ec = 1; else m_occ--;
      end
      if (we) m_thr = wd;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check("R3 strobe", stb, m_stb);
      check("R4 R5 kind", acc, m_acc);
      check("R5 flag", a2r, m_a2r);
      check("R2 occupancy", occ_o, m_occ);
      check("R6 throttle", thro, m_thro);
      check("R7 threshold", thr_o, m_thr);
      check("R8 count error", ecnt, m_ec);
      check("R9 fifo error", efifo, m_ef);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; l1 = 0; dv = 0; daq = 0; brd = 0; we = 0;
    idle(3); rst = 0;
  endtask

  initial begin
    int unsigned seed = 32'd12345;
    void'($urandom(seed));
    do_reset();
    // R1 reset state
    check("R1 occupancy", occ_o, 0);
    check("R1 threshold", thr_o, 990);
    check("R1 outputs", {stb, acc, a2r, thro, efifo, ecnt}, 0);
    // R2 R4 R9 R8: five accepts, then a burst of ten decisions
    repeat (5) begin l1 = 1; @(negedge clk); end
    l1 = 0;
    for (int i = 0; i < 10; i++) begin dv = 1; da = i[0] ^ i[2]; @(negedge clk); end
    dv = 0;
    idle(400);
    check("R9 overflow seen", efifo, 1);
    check("R8 underflow seen", ecnt, 1);
    // R5 conversion
    do_reset();
    daq = 1; repeat (3) begin l1 = 1; @(negedge clk); end
    l1 = 0; check("R5 flag raised", a2r, 1);
    for (int i = 0; i < 3; i++) begin dv = 1; da = 1; @(negedge clk); end
    dv = 0; idle(120); daq = 0; idle(2);
    // R7 R6 threshold
    we = 1; wd = 10'd20; @(negedge clk); we = 0;
    check("R7 readback", thr_o, 20);
    repeat (25) begin l1 = 1; @(negedge clk); end
    l1 = 0; idle(3);
    check("R6 threshold throttle", thro, 1);
    we = 1; wd = 10'd990; @(negedge clk); we = 0; idle(2);
    check("R6 throttle released", thro, 0);
    brd = 1; @(negedge clk); brd = 0;
    check("R6 board throttle", thro, 1);
    // R8 overflow at MAXE
    do_reset();
    repeat (MAXE) begin l1 = 1; @(negedge clk); end
    check("R8 full count", occ_o, MAXE);
    @(negedge clk); l1 = 0; idle(2);
    check("R8 saturates", occ_o, MAXE);
    check("R8 flag", ecnt, 1);
    check("R6 full throttle", thro, 1);
    // random phase
    do_reset();
    for (int c = 0; c < 20000; c++) begin
      l1  = ($urandom_range(0, 99) < 3);
      dv  = ($urandom_range(0, 99) < 3) || (c % 5000 < 12);
      da  = $urandom_range(0, 1);
      if ($urandom_range(0, 199) == 0) daq = ~daq;
      brd = ($urandom_range(0, 299) == 0);
      we  = ($urandom_range(0, 499) == 0);
      wd  = W'($urandom_range(0, 60));
      @(negedge clk);
    end
    l1 = 0; dv = 0; we = 0; idle(400);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule